// File: doc/BRIEF.md
# Dual-Channel Cutoff and Sample-Stage Control Logic

This block is the digital control side of a two-channel programmable filter. It keeps one 7-bit cutoff code per channel and three control flags: a power-down flag, an enable for the sampled output, and a choice of which channel feeds the sampler. A small parallel bus with an active-low select, an active-low write strobe, a 2-bit address and a data bus loads these settings. A write is level-sensitive: the addressed setting follows the data bus for as long as select and write are both low, and keeps its last value once either goes high.

A strap mode bypasses the bus completely. Both cutoff codes then follow the data pins together, and the three control flags come from dedicated strap pins. A digital track-and-hold stage passes the word of the selected channel through while its control is low, and freezes the word present when the control rises. Every asynchronous input crosses into the system clock through a two-flop synchronizer, and the floating of outputs during power-down or sample disable is modelled by deasserted valid flags with the sample word forced to zero.

Top module: `fltctl_top`

## Requirements
- R1: After reset both cutoff codes read 0, `chan_vld` and `smp_vld` are 1, and the sample path tracks channel A.
- R2: In bus mode, address 00 with `cs_n` and `wr_n` both low loads `data` into `code_a` (bit 6 is the MSB); `code_b` is untouched.
- R3: In bus mode, address 01 with `cs_n` and `wr_n` both low loads `data` into `code_b`; `code_a` is untouched.
- R4: A code keeps its value once `wr_n` goes high, whatever `data` does next, and `wr_n` low with `cs_n` high writes nothing.
- R5: Address 10 is the sample-control word: data bit 0 is the sample enable (1 = on) and data bit 1 the source (1 = channel A, 0 = channel B); bits 6..2 and both codes are unaffected.
- R6: Address 11 is the power word: data bit 0 = 0 powers down (`chan_vld` = 0), data bit 0 = 1 powers up; bits 6..1 are ignored and the codes are kept.
- R7: With `strap_mode` high both codes follow `data` together and `cs_n`, `wr_n` and `addr` have no effect; on leaving strap mode the codes keep the last strapped value.
- R8: With `strap_mode` high the flags come from `strap_awake` (0 = powered down), `strap_smp_en` and `strap_src_a`; with `strap_mode` low those pins have no effect.
- R9: While `hold` is low, `smp_word` follows the word of the selected channel.
- R10: On a rising `hold` the present word is captured and `smp_word` stays constant while `hold` stays high, even if the channel words or the source select change.
- R11: `smp_vld` is 1 only when powered up and sample-enabled; when `smp_vld` is 0, `smp_word` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 1 | 1 = settings taken from pins, 0 = bus mode |
| cs_n | input | 1 | Bus select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Bus address |
| data | input | 7 | Bus data / strapped cutoff code |
| strap_awake | input | 1 | Strap-mode power flag (0 = powered down) |
| strap_smp_en | input | 1 | Strap-mode sample enable |
| strap_src_a | input | 1 | Strap-mode source (1 = channel A) |
| hold | input | 1 | Track (0) / hold (1) control |
| word_a | input | 16 | Channel A data word |
| word_b | input | 16 | Channel B data word |
| code_a | output | 7 | Channel A cutoff code |
| code_b | output | 7 | Channel B cutoff code |
| chan_vld | output | 1 | Channel outputs driven (not powered down) |
| smp_vld | output | 1 | Sample output driven |
| smp_word | output | 16 | Tracked or held sample word |

## Verification
The code registers are driven with a sequence of bus states that separates a true write (select and write low) from a strobe released while data moves, a write strobe without select, and a strap-mode pass that must load both channels at once regardless of address. Control and power words are written with their don't-care bits set so a decoder that looks at too many bits shows up as a flag change. The sampler is tried with channel words and the source select changing while held, which separates a real freeze from plain tracking, and the strap pins are toggled in both modes to separate pin control from register control.

// File: rtl/fltctl_pkg.sv
package fltctl_pkg;

  typedef enum logic [1:0] {
    ADR_CODE_A = 2'b00,
    ADR_CODE_B = 2'b01,
    ADR_SMPCTL = 2'b10,
    ADR_POWER  = 2'b11
  } fc_addr_e;

  typedef struct packed {
    logic sleep;
    logic smp_en;
    logic src_a;
  } fc_ctl_t;

  localparam fc_ctl_t CTL_RESET = '{sleep: 1'b0, smp_en: 1'b1, src_a: 1'b1};

endpackage

// File: rtl/fltctl_sync.sv
module fltctl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] stg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= RST_VAL;
      else        stg_q <= chain[s];
    end
    assign chain[s+1] = stg_q;
  end

  assign q = chain[STAGES];

endmodule

// File: rtl/fltctl_regs.sv
module fltctl_regs
  import fltctl_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [CODE_W-1:0] data,
  input  fc_ctl_t           pin_ctl,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output fc_ctl_t           ctl_eff
);

  logic [CODE_W-1:0] code_a_q, code_a_nx;
  logic [CODE_W-1:0] code_b_q, code_b_nx;
  fc_ctl_t           ctl_q, ctl_nx;
  logic              wr_open;
  fc_addr_e          adr;

  always_comb begin
    adr       = fc_addr_e'(addr);
    wr_open   = !strap && !cs_n && !wr_n;
    code_a_nx = code_a_q;
    code_b_nx = code_b_q;
    ctl_nx    = ctl_q;
    if (strap) begin
      code_a_nx = data;
      code_b_nx = data;
    end else if (wr_open) begin
      case (adr)
        ADR_CODE_A: code_a_nx = data;
        ADR_CODE_B: code_b_nx = data;
        ADR_SMPCTL: begin
          ctl_nx.smp_en = data[0];
          ctl_nx.src_a  = data[1];
        end
        ADR_POWER:  ctl_nx.sleep = ~data[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_a_q <= '0;
      code_b_q <= '0;
      ctl_q    <= CTL_RESET;
    end else begin
      code_a_q <= code_a_nx;
      code_b_q <= code_b_nx;
      ctl_q    <= ctl_nx;
    end
  end

  assign code_a  = code_a_q;
  assign code_b  = code_b_q;
  assign ctl_eff = strap ? pin_ctl : ctl_q;

endmodule

// File: rtl/fltctl_trackhold.sv
module fltctl_trackhold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              src_a,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [WORD_W-1:0] smp_q
);

  logic              hold_d_q;
  logic              rise;
  logic              load;
  logic [WORD_W-1:0] smp_r, smp_nx;

  always_comb begin
    rise   = hold && !hold_d_q;
    load   = !hold || rise;
    smp_nx = smp_r;
    if (load) smp_nx = src_a ? word_a : word_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d_q <= 1'b0;
      smp_r    <= '0;
    end else begin
      hold_d_q <= hold;
      smp_r    <= smp_nx;
    end
  end

  assign smp_q = smp_r;

endmodule

// File: rtl/fltctl_top.sv
module fltctl_top
  import fltctl_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_mode,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [CODE_W-1:0] data,
  input  logic              strap_awake,
  input  logic              strap_smp_en,
  input  logic              strap_src_a,
  input  logic              hold,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              chan_vld,
  output logic              smp_vld,
  output logic [WORD_W-1:0] smp_word
);

  localparam int BANK_W = CODE_W + 9;
  localparam logic [BANK_W-1:0] BANK_RST =
    {1'b0, 1'b1, 1'b1, 2'b00, {CODE_W{1'b0}}, 3'b111, 1'b0};

  logic              rst_sn;
  logic [BANK_W-1:0] bank_raw, bank_s;
  logic              strap_s, cs_s, wr_s, hold_s;
  logic [1:0]        addr_s;
  logic [CODE_W-1:0] data_s;
  logic [2:0]        pins_s;
  fc_ctl_t           pin_ctl, ctl_eff;
  logic [WORD_W-1:0] smp_q;

  fltctl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn)
  );

  assign bank_raw = {strap_mode, cs_n, wr_n, addr, data,
                     strap_awake, strap_smp_en, strap_src_a, hold};

  fltctl_sync #(.W(BANK_W), .STAGES(SYNC_STAGES), .RST_VAL(BANK_RST)) u_in_sync (
    .clk(clk), .rst_n(rst_sn), .d(bank_raw), .q(bank_s)
  );

  assign {strap_s, cs_s, wr_s, addr_s, data_s, pins_s, hold_s} = bank_s;

  always_comb begin
    pin_ctl.sleep  = ~pins_s[2];
    pin_ctl.smp_en = pins_s[1];
    pin_ctl.src_a  = pins_s[0];
  end

  fltctl_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .strap(strap_s), .cs_n(cs_s), .wr_n(wr_s),
    .addr(addr_s), .data(data_s), .pin_ctl(pin_ctl),
    .code_a(code_a), .code_b(code_b), .ctl_eff(ctl_eff)
  );

  fltctl_trackhold #(.WORD_W(WORD_W)) u_th (
    .clk(clk), .rst_n(rst_sn), .hold(hold_s), .src_a(ctl_eff.src_a),
    .word_a(word_a), .word_b(word_b), .smp_q(smp_q)
  );

  assign chan_vld = ~ctl_eff.sleep;
  assign smp_vld  = chan_vld & ctl_eff.smp_en;
  assign smp_word = smp_vld ? smp_q : '0;

endmodule

// File: rtl/fltctl_chk.sv
module fltctl_chk #(
  parameter int CODE_W = 7,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_s,
  input logic              cs_s,
  input logic              wr_s,
  input logic [1:0]        addr_s,
  input logic              hold_s,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              chan_vld,
  input logic              smp_vld,
  input logic [WORD_W-1:0] smp_word
);

  assert_code_a_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_a != $past(code_a)) |->
      $past(strap_s || (!cs_s && !wr_s && addr_s == 2'b00)));

  assert_code_b_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_b != $past(code_b)) |->
      $past(strap_s || (!cs_s && !wr_s && addr_s == 2'b01)));

  assert_strap_tie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_s) |-> (code_a == code_b));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && $past(hold_s) && $past(hold_s, 2) && smp_vld && $past(smp_vld))
      |-> $stable(smp_word));

  assert_vld_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> chan_vld);

  assert_float_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |-> (smp_word == '0));

endmodule

bind fltctl_top fltctl_chk #(.CODE_W(CODE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_s(strap_s), .cs_s(cs_s), .wr_s(wr_s),
  .addr_s(addr_s), .hold_s(hold_s), .code_a(code_a), .code_b(code_b),
  .chan_vld(chan_vld), .smp_vld(smp_vld), .smp_word(smp_word)
);

// File: tb/tb_fltctl_top.sv
module tb_fltctl_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_mode, cs_n, wr_n;
  logic [1:0]  addr;
  logic [6:0]  data;
  logic        strap_awake, strap_smp_en, strap_src_a, hold;
  logic [15:0] word_a, word_b;
  logic [6:0]  code_a, code_b;
  logic        chan_vld, smp_vld;
  logic [15:0] smp_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fltctl_top dut (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .cs_n(cs_n), .wr_n(wr_n),
    .addr(addr), .data(data), .strap_awake(strap_awake), .strap_smp_en(strap_smp_en),
    .strap_src_a(strap_src_a), .hold(hold), .word_a(word_a), .word_b(word_b),
    .code_a(code_a), .code_b(code_b), .chan_vld(chan_vld), .smp_vld(smp_vld),
    .smp_word(smp_word)
  );

  // {strap, cs_n, wr_n, addr, data, expected code_a, expected code_b}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 7'h55, 7'h55, 7'h00},  // R2 write A
    {1'b0, 1'b0, 1'b1, 2'd0, 7'h2A, 7'h55, 7'h00},  // R4 strobe released
    {1'b0, 1'b1, 1'b0, 2'd1, 7'h11, 7'h55, 7'h00},  // R4 no select
    {1'b0, 1'b0, 1'b0, 2'd1, 7'h40, 7'h55, 7'h40},  // R3 write B
    {1'b0, 1'b0, 1'b0, 2'd1, 7'h7F, 7'h55, 7'h7F},  // R3 all ones
    {1'b0, 1'b1, 1'b1, 2'd0, 7'h01, 7'h55, 7'h7F},  // R4 idle
    {1'b1, 1'b1, 1'b1, 2'd2, 7'h33, 7'h33, 7'h33},  // R7 strap
    {1'b1, 1'b0, 1'b0, 2'd1, 7'h0C, 7'h0C, 7'h0C},  // R7 bus pins ignored
    {1'b0, 1'b1, 1'b1, 2'd0, 7'h7E, 7'h0C, 7'h0C}   // R7 codes kept after strap
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; data = d;
    settle();
    cs_n = 1'b1; wr_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strap_mode = 1'b0; cs_n = 1'b1; wr_n = 1'b1; addr = 2'd0;
    data = 7'h00; strap_awake = 1'b1; strap_smp_en = 1'b1; strap_src_a = 1'b1;
    hold = 1'b0; word_a = 16'h1234; word_b = 16'hABCD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk(code_a == 7'h00, "R1 code_a", 32'(code_a), 32'h0);
    chk(code_b == 7'h00, "R1 code_b", 32'(code_b), 32'h0);
    chk(chan_vld && smp_vld, "R1 valid flags", {30'd0, chan_vld, smp_vld}, 32'h3);
    chk(smp_word == 16'h1234, "R1 tracks A", 32'(smp_word), 32'h1234);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {strap_mode, cs_n, wr_n, addr, data} = VEC[i][25:14];
      settle();
      chk(code_a == VEC[i][13:7], "R2/R4/R7 code_a vector", 32'(code_a), 32'(VEC[i][13:7]));
      chk(code_b == VEC[i][6:0],  "R3/R4/R7 code_b vector", 32'(code_b), 32'(VEC[i][6:0]));
    end

    // R9 tracking follows word changes
    word_a = 16'h0F0F;
    settle();
    chk(smp_word == 16'h0F0F, "R9 track A", 32'(smp_word), 32'h0F0F);

    // R5 sample control, high bits set as don't-care
    bus_wr(2'd2, 7'b1111100);
    chk(!smp_vld && chan_vld, "R5 enable off", {30'd0, chan_vld, smp_vld}, 32'h2);
    chk(smp_word == 16'h0, "R11 floated word", 32'(smp_word), 32'h0);
    bus_wr(2'd2, 7'b1010101);
    chk(smp_vld && smp_word == 16'hABCD, "R5 source B", 32'(smp_word), 32'hABCD);
    chk(code_a == 7'h0C && code_b == 7'h0C, "R5 codes kept", 32'({code_a, code_b}), 32'h060C);

    // R10 hold
    hold = 1'b1;
    settle();
    word_b = 16'h5555;
    settle();
    chk(smp_word == 16'hABCD, "R10 held vs word change", 32'(smp_word), 32'hABCD);
    bus_wr(2'd2, 7'b0000011);
    chk(smp_word == 16'hABCD, "R10 held vs source change", 32'(smp_word), 32'hABCD);
    hold = 1'b0;
    settle();
    chk(smp_word == 16'h0F0F, "R9 track after release", 32'(smp_word), 32'h0F0F);

    // R6 power word
    bus_wr(2'd3, 7'b1111110);
    chk(!chan_vld && !smp_vld, "R6 powered down", {30'd0, chan_vld, smp_vld}, 32'h0);
    chk(smp_word == 16'h0, "R11 word zero when down", 32'(smp_word), 32'h0);
    chk(code_b == 7'h0C, "R6 code kept", 32'(code_b), 32'h0C);
    bus_wr(2'd3, 7'b0000001);
    chk(chan_vld && smp_vld, "R6 powered up", {30'd0, chan_vld, smp_vld}, 32'h3);

    // R8 pins ignored in bus mode
    strap_awake = 1'b0; strap_smp_en = 1'b0;
    settle();
    chk(chan_vld && smp_vld, "R8 pins ignored", {30'd0, chan_vld, smp_vld}, 32'h3);

    // R8 strap mode pin control
    strap_mode = 1'b1; strap_awake = 1'b1; strap_smp_en = 1'b1; strap_src_a = 1'b0;
    data = 7'h21;
    settle();
    chk(smp_vld && smp_word == 16'h5555, "R8 strap source B", 32'(smp_word), 32'h5555);
    chk(code_a == 7'h21 && code_b == 7'h21, "R7 strap codes", 32'({code_a, code_b}), 32'h10A1);
    strap_awake = 1'b0;
    settle();
    chk(!chan_vld, "R8 strap power down", 32'(chan_vld), 32'h0);
    strap_mode = 1'b0; strap_awake = 1'b1; strap_src_a = 1'b1;
    settle();
    chk(chan_vld && smp_word == 16'h0F0F, "R8 back to registers", 32'(smp_word), 32'h0F0F);
    chk(code_a == 7'h21, "R7 code kept after strap", 32'(code_a), 32'h21);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule